// File: doc/BRIEF.md
# Toroidal Eight-Neighbour Bit-Serial Mesh

This block is the data-movement fabric for a two-dimensional array of SIMD processing elements. Every element holds a W-bit word in a shift register. When a transfer command is accepted, all elements shift together, one bit per clock, and the bits move toward one of eight compass directions chosen by a single direction code shared by the whole array. The array wraps in both axes, so an element on the south edge sends to the north edge and one on the east edge sends to the west edge.

Straight transfers (north, east, south, west) use direct links between neighbours. Diagonal transfers pass through crossing nodes. Each node sits at the corner shared by four elements and steers one bit along one of its two diagonals, in one sense. Each element therefore has four straight links, and one crossing node per element covers all four diagonal directions. Each element also has an enable. A disabled element sends zeros and keeps its word.

Words are written into the array through a parallel load port and read back through a parallel output port. The command port uses a valid/ready handshake. `cmd_ready` is high only while the fabric is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, `cmd_valid` is ignored, so the sender must hold the command until it is accepted. `done` pulses for one cycle when the transfer has finished.

Top module: `mesh_fabric`

## Requirements
- R1: After reset every stored word is zero, `cmd_ready` is 1 and `done` is 0.
- R2: A `load` pulse while idle writes `load_data` into every element on the next edge. Element i = row*COLS+col takes bits [i*W +: W]. Row 0 is the northmost row and column 0 is the westmost column. A `load` while a transfer is running is ignored.
- R3: The direction codes are 0=N, 1=NE, 2=E, 3=SE, 4=S, 5=SW, 6=W, 7=NW. North means row-1 and east means col+1. At the end of a straight transfer, the enabled element at (r,c) holds the original word of the element at (r-dr, c-dc).
- R4: Row and column indices wrap modulo ROWS and COLS, so edge elements exchange words with the opposite edge.
- R5: Diagonal transfers follow the same rule as R3, with both offsets nonzero (NE = (-1,+1), SE = (+1,+1), SW = (+1,-1), NW = (-1,-1)), and are carried through the shared crossing nodes.
- R6: A transfer takes exactly W clocks. `cmd_ready` is low from the edge after acceptance until `done` rises. `done` goes high W edges after the accepting edge, for exactly one cycle.
- R7: An element whose enable is low keeps its word through a transfer.
- R8: An enabled element whose source element is disabled ends the transfer holding all zeros.
- R9: The direction is captured when the command is accepted. Changes on `cmd_dir` during a transfer have no effect.
- R10: `cmd_valid` asserted while `cmd_ready` is low is ignored. No second transfer starts after the current one finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Parallel write of all words, honoured only while idle |
| load_data | input | ROWS*COLS*W | Words to load, element i at bits [i*W +: W] |
| elem_en | input | ROWS*COLS | Per-element enable, bit i for element i |
| cmd_valid | input | 1 | Transfer command valid |
| cmd_dir | input | 3 | Transfer direction code |
| cmd_ready | output | 1 | Fabric idle and able to accept a command |
| done | output | 1 | One-cycle pulse when a transfer completes |
| word_out | output | ROWS*COLS*W | Current word of every element |

## Verification
On every cycle the assertions check the handshake and timing rules: a transfer starts right after acceptance, `done` is a one-cycle pulse that only follows a busy period, and the latched direction holds steady during a transfer. They also check that a disabled element's register stays unchanged. The bench scenarios are the only evidence for where the data lands: the eight direction mappings, wrapping at the edges, the routing through the crossing nodes, zeros coming from a disabled source, and the exact clock count of each transfer. The same holds for ignoring a load, a direction change or a repeated command during a transfer.

// File: rtl/mesh_pkg.sv
package mesh_pkg;
  typedef enum logic [2:0] {
    DIR_N  = 3'd0,
    DIR_NE = 3'd1,
    DIR_E  = 3'd2,
    DIR_SE = 3'd3,
    DIR_S  = 3'd4,
    DIR_SW = 3'd5,
    DIR_W  = 3'd6,
    DIR_NW = 3'd7
  } dir_e;
endpackage

// File: rtl/mesh_ctrl.sv
module mesh_ctrl #(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_dir,
  output logic             cmd_ready,
  output logic             shift,
  output logic             done,
  output mesh_pkg::dir_e   dir_q
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      done  <= 1'b0;
      dir_q <= mesh_pkg::DIR_N;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy  <= 1'b1;
          cnt   <= '0;
          dir_q <= mesh_pkg::dir_e'(cmd_dir);
        end
      end else if (cnt == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign cmd_ready = !busy;
  assign shift     = busy;

  // R6: an accepted command starts a transfer on the next cycle
  a_r6_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);
  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: done only ends a busy period
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready && !$past(cmd_ready));
  // R9: latched direction steady inside a transfer
  a_r9_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cnt != LAST) |=> $stable(dir_q));
endmodule

// File: rtl/mesh_xnode.sv
module mesh_xnode (
  input  mesh_pkg::dir_e dir,
  input  logic           in_nw,
  input  logic           in_ne,
  input  logic           in_sw,
  input  logic           in_se,
  output logic           out_nw,
  output logic           out_ne,
  output logic           out_sw,
  output logic           out_se
);
  always_comb begin
    out_nw = 1'b0;
    out_ne = 1'b0;
    out_sw = 1'b0;
    out_se = 1'b0;
    unique case (dir)
      mesh_pkg::DIR_NE: out_ne = in_sw;
      mesh_pkg::DIR_SW: out_sw = in_ne;
      mesh_pkg::DIR_SE: out_se = in_nw;
      mesh_pkg::DIR_NW: out_nw = in_se;
      default: ;
    endcase
  end

  // R5: a crossing steers at most one corner at a time
  always_comb a_r5_one_path: assert ($onehot0({out_nw, out_ne, out_sw, out_se}));
endmodule

// File: rtl/mesh_pe.sv
module mesh_pe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         rx,
  output logic         tx,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)           q <= '0;
    else if (load)        q <= load_word;
    else if (shift && en) q <= {rx, q[W-1:1]};
  end

  assign tx = en & q[0];

  // R7: a disabled element keeps its word while shifting
  a_r7_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    shift && !en && !load |=> $stable(q));
endmodule

// File: rtl/mesh_fabric.sv
module mesh_fabric #(
  parameter int ROWS = 4,
  parameter int COLS = 8,
  parameter int W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [ROWS*COLS*W-1:0]   load_data,
  input  logic [ROWS*COLS-1:0]     elem_en,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_dir,
  output logic                     cmd_ready,
  output logic                     done,
  output logic [ROWS*COLS*W-1:0]   word_out
);
  localparam int N = ROWS * COLS;

  mesh_pkg::dir_e dir_q;
  logic           shift;
  logic           load_ok;
  logic [N-1:0]   tx, rx;
  logic [N-1:0]   xo_nw, xo_ne, xo_sw, xo_se;

  mesh_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dir(cmd_dir),
    .cmd_ready(cmd_ready), .shift(shift), .done(done), .dir_q(dir_q)
  );

  assign load_ok = load && cmd_ready;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int RM = (r + ROWS - 1) % ROWS;
      localparam int RP = (r + 1) % ROWS;
      localparam int CM = (c + COLS - 1) % COLS;
      localparam int CP = (c + 1) % COLS;
      localparam int ID = r * COLS + c;

      // crossing node at the south-east corner of element (r,c)
      mesh_xnode u_x (
        .dir(dir_q),
        .in_nw(tx[ID]), .in_ne(tx[r*COLS+CP]),
        .in_sw(tx[RP*COLS+c]), .in_se(tx[RP*COLS+CP]),
        .out_nw(xo_nw[ID]), .out_ne(xo_ne[ID]),
        .out_sw(xo_sw[ID]), .out_se(xo_se[ID])
      );

      always_comb begin
        unique case (dir_q)
          mesh_pkg::DIR_N:  rx[ID] = tx[RP*COLS+c];
          mesh_pkg::DIR_E:  rx[ID] = tx[r*COLS+CM];
          mesh_pkg::DIR_S:  rx[ID] = tx[RM*COLS+c];
          mesh_pkg::DIR_W:  rx[ID] = tx[r*COLS+CP];
          mesh_pkg::DIR_NE: rx[ID] = xo_ne[r*COLS+CM];
          mesh_pkg::DIR_SW: rx[ID] = xo_sw[RM*COLS+c];
          mesh_pkg::DIR_SE: rx[ID] = xo_se[RM*COLS+CM];
          mesh_pkg::DIR_NW: rx[ID] = xo_nw[ID];
          default:          rx[ID] = 1'b0;
        endcase
      end

      mesh_pe #(.W(W)) u_pe (
        .clk(clk), .rst_n(rst_n), .shift(shift), .en(elem_en[ID]),
        .load(load_ok), .load_word(load_data[ID*W +: W]),
        .rx(rx[ID]), .tx(tx[ID]), .q(word_out[ID*W +: W])
      );
    end
  end

  // R2: a load during a transfer leaves disabled elements untouched
  a_r2_load_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready && !done && (elem_en == '0) |=> $stable(word_out));
endmodule

// File: tb/mesh_fabric_bench.sv
module mesh_fabric_bench;
  localparam int ROWS = 4;
  localparam int COLS = 8;
  localparam int W    = 8;
  localparam int N    = ROWS * COLS;
  localparam int NV   = 11;
  // {dir, enable mask}
  localparam logic [34:0] VEC [NV] = '{
    {3'd0, 32'hFFFF_FFFF}, {3'd1, 32'hFFFF_FFFF}, {3'd2, 32'hFFFF_FFFF},
    {3'd3, 32'hFFFF_FFFF}, {3'd4, 32'hFFFF_FFFF}, {3'd5, 32'hFFFF_FFFF},
    {3'd6, 32'hFFFF_FFFF}, {3'd7, 32'hFFFF_FFFF}, {3'd3, 32'hA5A5_0F0F},
    {3'd6, 32'h0000_FFFF}, {3'd1, 32'h3C3C_C3C3}
  };

  logic clk = 0, rst_n = 0, load = 0, cmd_valid = 0;
  logic [N*W-1:0] load_data = '0;
  logic [N-1:0]   elem_en = '0;
  logic [2:0]     cmd_dir = '0;
  logic           cmd_ready, done;
  logic [N*W-1:0] word_out;
  logic [W-1:0]   orig [N];
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  mesh_fabric #(.ROWS(ROWS), .COLS(COLS), .W(W)) u_mesh_fabric (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
    .elem_en(elem_en), .cmd_valid(cmd_valid), .cmd_dir(cmd_dir),
    .cmd_ready(cmd_ready), .done(done), .word_out(word_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void delta(input logic [2:0] d, output int dr, output int dc);
    case (d)
      3'd0: begin dr = -1; dc =  0; end
      3'd1: begin dr = -1; dc =  1; end
      3'd2: begin dr =  0; dc =  1; end
      3'd3: begin dr =  1; dc =  1; end
      3'd4: begin dr =  1; dc =  0; end
      3'd5: begin dr =  1; dc = -1; end
      3'd6: begin dr =  0; dc = -1; end
      default: begin dr = -1; dc = -1; end
    endcase
  endfunction

  task automatic do_load(input logic [N*W-1:0] data);
    @(negedge clk); load = 1; load_data = data;
    @(negedge clk); load = 0;
  endtask

  // mode 0: plain, 1: poke dir and repeated valid during transfer, 2: load during transfer
  task automatic run_cmd(input logic [2:0] d, input logic [N-1:0] m, input int mode);
    elem_en = m;
    @(negedge clk); cmd_valid = 1; cmd_dir = d;
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_ready == 0, "R6 busy after accept", cmd_ready, 0);
    if (mode == 1) begin cmd_valid = 1; cmd_dir = d + 3'd2; end
    if (mode == 2) begin load = 1; load_data = '1; end
    for (int i = 1; i < W; i++) begin
      @(negedge clk);
      load = 0;
      if (i == W - 1) cmd_valid = 0;
      chk(done == 0, "R6 done early", done, 0);
    end
    @(negedge clk);
    chk(done == 1, "R6 done after W clocks", done, 1);
    @(negedge clk);
    chk(done == 0 && cmd_ready == 1, "R10 no extra transfer / R6 pulse", {done, cmd_ready}, 2'b01);
  endtask

  task automatic check_words(input logic [2:0] d, input logic [N-1:0] m);
    int dr, dc;
    delta(d, dr, dc);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int sr, sc, si, di;
        logic [W-1:0] exp;
        string tag;
        sr = r - dr; sc = c - dc;
        tag = (dr != 0 && dc != 0) ? "R5 diagonal" : "R3 straight";
        if (sr < 0 || sr >= ROWS || sc < 0 || sc >= COLS) tag = "R4 wrap";
        sr = (sr + ROWS) % ROWS; sc = (sc + COLS) % COLS;
        si = sr * COLS + sc; di = r * COLS + c;
        if (!m[di]) begin exp = orig[di]; tag = "R7 disabled hold"; end
        else if (!m[si]) begin exp = '0; tag = "R8 zero from disabled"; end
        else exp = orig[si];
        chk(word_out[di*W +: W] == exp, tag, word_out[di*W +: W], exp);
      end
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N*W-1:0] flat;
    for (int i = 0; i < N; i++) orig[i] = W'(i * 37 + 11);
    for (int i = 0; i < N; i++) flat[i*W +: W] = orig[i];
    repeat (3) @(negedge clk);
    chk(word_out == '0, "R1 words zero", word_out[31:0], 0);
    chk(cmd_ready == 1 && done == 0, "R1 idle", {cmd_ready, done}, 2'b10);
    rst_n = 1;
    @(negedge clk);
    do_load(flat);
    chk(word_out == flat, "R2 load", word_out[31:0], flat[31:0]);

    for (int v = 0; v < NV; v++) begin
      do_load(flat);
      run_cmd(VEC[v][34:32], VEC[v][31:0], 0);
      check_words(VEC[v][34:32], VEC[v][31:0]);
    end

    // R9 + R10: direction change and repeated valid during a transfer
    do_load(flat);
    run_cmd(3'd2, '1, 1);
    check_words(3'd2, '1);
    // R2: load during transfer is ignored
    do_load(flat);
    run_cmd(3'd7, '1, 2);
    check_words(3'd7, '1);
    // R7: all disabled, nothing moves
    do_load(flat);
    run_cmd(3'd4, '0, 0);
    chk(word_out == flat, "R7 all disabled", word_out[31:0], flat[31:0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule